// File: doc/BRIEF.md
# Block Link Receive Frame Parser

This block parses frames on the receive side of a half-duplex block link. Bytes arrive one per cycle on a byte input. The first byte of a frame carries a start strobe, and a separate end strobe closes the frame. Each frame holds an address byte, a control byte, a length byte, up to 254 payload bytes and a 16-bit check code. The parser stores the three header bytes and passes each payload byte to a byte output as it arrives. It keeps a running CRC over the header and payload, and compares the result with the two trailing bytes.

When the end strobe arrives, the parser reports one result: a good-frame pulse, or an error pulse with a cause code. The cause code tells the link layer above whether to answer with a CRC-error acknowledge or an other-error acknowledge. Alongside the result, the parser decodes the control byte into its block kind (information, acknowledge or supervisory) and the fields that kind carries. The higher layer reads these fields to decide how to respond. That decision is not part of this block.

Top module: `t1_frame_parser`

## Requirements
- R1: In the cycle after reset is released, every output is zero.
- R2: Payload bytes are the bytes at positions 3 up to 3+LEN-1, where position 0 is the byte with the start strobe and LEN is the byte at position 2. Each payload byte appears on `pay_data`, with `pay_valid` high, one cycle after it is accepted, in arrival order. Header and check bytes never appear on `pay_data`.
- R3: In the cycle after an `in_eof` that closes an open frame, exactly one of `frame_valid` and `frame_error` pulses for one cycle. An `in_eof` with no open frame, or bytes that arrive with no open frame, produce nothing. A start strobe in the middle of a frame discards the partial frame.
- R4: The check code is CRC-16 with reflected polynomial 0x1021 (shift constant 0x8408), initial value 0xFFFF and final XOR 0xFFFF. It covers the header and payload bytes, and its low byte is sent first. On a mismatch, `frame_error` pulses with `err_cause` = 01. A good frame gives `err_cause` = 00.
- R5: A control byte with bit 7 = 0 is an information block: `blk_kind` = 00, `seq_no` = bit 6, `more_data` = bit 5. If any of bits 4..0 is set, the frame is reported as other error (`err_cause` = 10).
- R6: A control byte with bits 7..6 = 10 is an acknowledge block: `blk_kind` = 10, `seq_no` = bit 4, `ack_code` = bits 1..0. The frame is reported as other error if bit 5, bit 3 or bit 2 is set, if the code is 11, or if LEN is not 0.
- R7: A control byte with bits 7..6 = 11 is a supervisory block: `blk_kind` = 11, `sup_resp` = bit 5, `sup_code` = bits 4..0. Only the codes 0, 1, 2, 3, 5, 6, 7 and 0x0F are accepted. Any other code gives other error.
- R8: An address byte of 0x00 or 0xFF, or one whose upper nibble equals its lower nibble, gives other error.
- R9: A LEN of 0xFF, or a LEN greater than `ifs_max` (sampled when `in_eof` arrives), gives other error.
- R10: A frame whose byte count is not LEN+5 gives other error. This covers frames that end early and frames with extra bytes.
- R11: The error causes follow a fixed priority. A wrong byte count reports other error. Otherwise a check code mismatch reports CRC error, even when the header is also malformed.
- R12: The decoded control fields are updated with every result pulse and held until the next one. Fields that do not belong to the decoded kind read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Marks the first byte of a frame (together with `in_valid`) |
| in_eof | input | 1 | End of frame; given in a cycle with no byte, since a byte in that cycle is dropped |
| ifs_max | input | 8 | Current negotiated maximum payload length |
| pay_valid | output | 1 | `pay_data` holds a payload byte |
| pay_data | output | 8 | Forwarded payload byte |
| frame_valid | output | 1 | One-cycle pulse for a good frame |
| frame_error | output | 1 | One-cycle pulse for a rejected frame |
| err_cause | output | 2 | 00 none, 01 CRC error, 10 other error |
| blk_kind | output | 2 | 00 information, 10 acknowledge, 11 supervisory |
| seq_no | output | 1 | Send sequence number (information) or expected number (acknowledge) |
| more_data | output | 1 | Chaining flag of an information block |
| ack_code | output | 2 | Error code of an acknowledge block |
| sup_resp | output | 1 | Supervisory block is a response |
| sup_code | output | 5 | Supervisory command code |

## Verification
The hardest cases to reach are those where two faults occur in the same frame, and those where a frame is cut off partway through. In these cases the cause priority and the payload forwarding must both behave correctly. The stimulus builds frames with a correct check code and then changes them: it flips a check bit in a frame that also has a bad address, drops the final byte, appends an extra byte, or raises a fresh start strobe after only the header. A length of 0xFF with a full 255-byte body checks that the byte counter keeps counting past the normal limit. Stray bytes and end strobes sent while no frame is open check that they produce no pulse.

// File: rtl/t1p_pkg.sv
package t1p_pkg;

    localparam int HDR_BYTES = 3;
    localparam int CRC_BYTES = 2;

    localparam logic [15:0] CRC_INIT      = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam logic [15:0] CRC_XOROUT    = 16'hFFFF;

    typedef enum logic [1:0] {
        KIND_INFO = 2'b00,
        KIND_ACK  = 2'b10,
        KIND_SUP  = 2'b11
    } blk_kind_t;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'b00,
        CAUSE_CRC   = 2'b01,
        CAUSE_OTHER = 2'b10
    } cause_t;

    typedef struct packed {
        blk_kind_t  kind;
        logic       seq;
        logic       more;
        logic [1:0] ack_code;
        logic       sup_resp;
        logic [4:0] sup_code;
    } pcb_fields_t;

    // One byte of the reflected CRC, data taken least significant bit first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic sup_code_known(input logic [4:0] code);
        case (code)
            5'h00, 5'h01, 5'h02, 5'h03,
            5'h05, 5'h06, 5'h07, 5'h0F: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    function automatic logic addr_ok(input logic [7:0] a);
        return (a != 8'h00) && (a != 8'hFF) && (a[7:4] != a[3:0]);
    endfunction

endpackage

// File: rtl/t1p_crc16.sv
module t1p_crc16
    import t1p_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)          crc <= CRC_INIT;
        else if (restart) crc <= crc_step(CRC_INIT, data);
        else if (en)      crc <= crc_step(crc, data);
    end
endmodule

// File: rtl/t1p_pcb_decode.sv
module t1p_pcb_decode
    import t1p_pkg::*;
(
    input  logic [7:0]  pcb,
    output pcb_fields_t fields,
    output logic        pcb_ok
);
    always_comb begin
        fields = '0;
        pcb_ok = 1'b0;
        if (!pcb[7]) begin
            fields.kind = KIND_INFO;
            fields.seq  = pcb[6];
            fields.more = pcb[5];
            pcb_ok      = (pcb[4:0] == 5'b0);
        end else if (!pcb[6]) begin
            fields.kind     = KIND_ACK;
            fields.seq      = pcb[4];
            fields.ack_code = pcb[1:0];
            pcb_ok          = !pcb[5] && (pcb[3:2] == 2'b00) && (pcb[1:0] != 2'b11);
        end else begin
            fields.kind     = KIND_SUP;
            fields.sup_resp = pcb[5];
            fields.sup_code = pcb[4:0];
            pcb_ok          = sup_code_known(pcb[4:0]);
        end
    end
endmodule

// File: rtl/t1p_byte_track.sv
module t1p_byte_track
    import t1p_pkg::*;
#(
    parameter  int LEN_W    = 8,
    localparam int FULL_MAX = (1 << LEN_W) - 1 + HDR_BYTES + CRC_BYTES,
    localparam int CNT_W    = $clog2(FULL_MAX + 1) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output logic [7:0]       nad,
    output logic [7:0]       pcb,
    output logic [LEN_W-1:0] len,
    output logic [15:0]      rx_crc,
    output logic             crc_restart,
    output logic             crc_en,
    output logic             pay_valid,
    output logic [7:0]       pay_data
);
    logic             take, start_b, cont_b, hdr_pos, pay_pos;
    logic [CNT_W-1:0] pay_end;

    assign take    = in_valid && !in_eof;
    assign start_b = take && in_sof;
    assign cont_b  = take && !in_sof && active;
    assign pay_end = CNT_W'(len) + CNT_W'(HDR_BYTES);
    assign hdr_pos = cnt < CNT_W'(HDR_BYTES);
    assign pay_pos = !hdr_pos && (cnt < pay_end);

    assign crc_restart = start_b;
    assign crc_en      = cont_b && (hdr_pos || pay_pos);

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            cnt       <= '0;
            nad       <= '0;
            pcb       <= '0;
            len       <= '0;
            rx_crc    <= '0;
            pay_valid <= 1'b0;
            pay_data  <= '0;
        end else begin
            pay_valid <= cont_b && pay_pos;
            pay_data  <= in_data;
            if (start_b) begin
                active <= 1'b1;
                cnt    <= CNT_W'(1);
                nad    <= in_data;
                len    <= '0;
            end else if (cont_b) begin
                if (cnt != '1) cnt <= cnt + CNT_W'(1);
                if (cnt == CNT_W'(1))       pcb          <= in_data;
                if (cnt == CNT_W'(2))       len          <= in_data[LEN_W-1:0];
                if (cnt == pay_end)         rx_crc[7:0]  <= in_data;
                if (cnt == pay_end + CNT_W'(1)) rx_crc[15:8] <= in_data;
            end else if (in_eof) begin
                active <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/t1_frame_parser.sv
module t1_frame_parser
    import t1p_pkg::*;
#(
    parameter  int LEN_W    = 8,
    localparam int FULL_MAX = (1 << LEN_W) - 1 + HDR_BYTES + CRC_BYTES,
    localparam int CNT_W    = $clog2(FULL_MAX + 1) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic [LEN_W-1:0] ifs_max,
    output logic             pay_valid,
    output logic [7:0]       pay_data,
    output logic             frame_valid,
    output logic             frame_error,
    output logic [1:0]       err_cause,
    output logic [1:0]       blk_kind,
    output logic             seq_no,
    output logic             more_data,
    output logic [1:0]       ack_code,
    output logic             sup_resp,
    output logic [4:0]       sup_code
);
    logic             trk_active, crc_restart, crc_en, pcb_ok;
    logic [CNT_W-1:0] trk_cnt;
    logic [7:0]       trk_nad, trk_pcb;
    logic [LEN_W-1:0] trk_len;
    logic [15:0]      rx_crc, crc_q;
    pcb_fields_t      dec_fields, fields_q;
    cause_t           cause;
    logic             count_ok, crc_ok, len_ok, shape_ok;

    t1p_byte_track #(.LEN_W(LEN_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_sof      (in_sof),
        .in_eof      (in_eof),
        .active      (trk_active),
        .cnt         (trk_cnt),
        .nad         (trk_nad),
        .pcb         (trk_pcb),
        .len         (trk_len),
        .rx_crc      (rx_crc),
        .crc_restart (crc_restart),
        .crc_en      (crc_en),
        .pay_valid   (pay_valid),
        .pay_data    (pay_data)
    );

    t1p_crc16 u_crc (
        .clk     (clk),
        .rst     (rst),
        .restart (crc_restart),
        .en      (crc_en),
        .data    (in_data),
        .crc     (crc_q)
    );

    t1p_pcb_decode u_dec (
        .pcb    (trk_pcb),
        .fields (dec_fields),
        .pcb_ok (pcb_ok)
    );

    always_comb begin
        count_ok = trk_cnt == (CNT_W'(trk_len) + CNT_W'(HDR_BYTES + CRC_BYTES));
        crc_ok   = (crc_q ^ CRC_XOROUT) == rx_crc;
        len_ok   = (trk_len <= ifs_max) && (trk_len != '1);
        shape_ok = pcb_ok && ((dec_fields.kind != KIND_ACK) || (trk_len == '0));
        if (!count_ok)                                    cause = CAUSE_OTHER;
        else if (!crc_ok)                                 cause = CAUSE_CRC;
        else if (!(addr_ok(trk_nad) && len_ok && shape_ok)) cause = CAUSE_OTHER;
        else                                              cause = CAUSE_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_valid <= 1'b0;
            frame_error <= 1'b0;
            err_cause   <= CAUSE_NONE;
            fields_q    <= '0;
        end else begin
            frame_valid <= 1'b0;
            frame_error <= 1'b0;
            if (in_eof && trk_active) begin
                frame_valid <= (cause == CAUSE_NONE);
                frame_error <= (cause != CAUSE_NONE);
                err_cause   <= cause;
                fields_q    <= dec_fields;
            end
        end
    end

    assign blk_kind  = fields_q.kind;
    assign seq_no    = fields_q.seq;
    assign more_data = fields_q.more;
    assign ack_code  = fields_q.ack_code;
    assign sup_resp  = fields_q.sup_resp;
    assign sup_code  = fields_q.sup_code;
endmodule

// File: rtl/t1_frame_parser_chk.sv
module t1_frame_parser_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_eof,
    input logic       pay_valid,
    input logic       frame_valid,
    input logic       frame_error,
    input logic [1:0] err_cause,
    input logic [1:0] blk_kind,
    input logic       more_data,
    input logic [1:0] ack_code,
    input logic [4:0] sup_code
);
    assert_one_result_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_valid, frame_error}));

    assert_result_follows_eof_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid || frame_error) |-> $past(in_eof));

    assert_result_single_cycle_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_valid || frame_error) |=> !(frame_valid || frame_error));

    assert_payload_has_source_R2: assert property (@(posedge clk) disable iff (rst)
        pay_valid |-> $past(in_valid && !in_eof));

    assert_error_cause_coded_R4: assert property (@(posedge clk) disable iff (rst)
        frame_error |-> (err_cause == 2'b01 || err_cause == 2'b10));

    assert_good_cause_clear_R4: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> err_cause == 2'b00);

    assert_good_ack_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && blk_kind == 2'b10) |-> (ack_code != 2'b11 && !more_data));

    assert_good_sup_code_R7: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && blk_kind == 2'b11) |->
            (sup_code inside {5'h00, 5'h01, 5'h02, 5'h03, 5'h05, 5'h06, 5'h07, 5'h0F}));
endmodule

bind t1_frame_parser t1_frame_parser_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_eof      (in_eof),
    .pay_valid   (pay_valid),
    .frame_valid (frame_valid),
    .frame_error (frame_error),
    .err_cause   (err_cause),
    .blk_kind    (blk_kind),
    .more_data   (more_data),
    .ack_code    (ack_code),
    .sup_code    (sup_code)
);

// File: tb/t1_frame_parser_bench.sv
module t1_frame_parser_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00, ifs_max = 8'd254;
    logic       pay_valid, frame_valid, frame_error, seq_no, more_data, sup_resp;
    logic [7:0] pay_data;
    logic [1:0] err_cause, blk_kind, ack_code;
    logic [4:0] sup_code;

    always #10 clk = ~clk;

    t1_frame_parser u_t1_frame_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .ifs_max(ifs_max),
        .pay_valid(pay_valid), .pay_data(pay_data),
        .frame_valid(frame_valid), .frame_error(frame_error), .err_cause(err_cause),
        .blk_kind(blk_kind), .seq_no(seq_no), .more_data(more_data),
        .ack_code(ack_code), .sup_resp(sup_resp), .sup_code(sup_code)
    );

    typedef struct {
        logic [1:0] cause;
        logic [1:0] kind;
        logic       seq, more;
        logic [1:0] ack;
        logic       resp;
        logic [4:0] code;
        string      req;
    } exp_t;

    exp_t       res_q[$];
    logic [7:0] pay_q[$];
    int         errors = 0, checks = 0;
    bit         done = 0;

    function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (b[i]) begin
            c = c ^ {8'h00, b[i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic build(input logic [7:0] nad, input logic [7:0] pcb, input logic [7:0] len,
                         input int npay, input int seed, output logic [7:0] f[$]);
        logic [15:0] c;
        f = {};
        f.push_back(nad); f.push_back(pcb); f.push_back(len);
        for (int i = 0; i < npay; i++) f.push_back(8'(seed + i * 7));
        c = ref_crc(f);
        f.push_back(c[7:0]); f.push_back(c[15:8]);
    endtask

    function automatic exp_t mk(input logic [7:0] pcb, input logic [1:0] cause, input string req);
        exp_t e;
        e.cause = cause; e.req = req;
        e.kind = 2'b00; e.seq = 0; e.more = 0; e.ack = 2'b00; e.resp = 0; e.code = 5'd0;
        if (!pcb[7]) begin
            e.seq = pcb[6]; e.more = pcb[5];
        end else if (!pcb[6]) begin
            e.kind = 2'b10; e.seq = pcb[4]; e.ack = pcb[1:0];
        end else begin
            e.kind = 2'b11; e.resp = pcb[5]; e.code = pcb[4:0];
        end
        return e;
    endfunction

    task automatic check_drained(input string req);
        checks++;
        if (res_q.size() != 0 || pay_q.size() != 0) begin
            errors++;
            $display("FAIL %s: pending results=%0d payload=%0d, expected 0 and 0",
                     req, res_q.size(), pay_q.size());
        end
        res_q = {}; pay_q = {};
    endtask

    task automatic drive_bytes(input logic [7:0] f[$], input bit with_sof);
        foreach (f[i]) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = f[i]; in_sof = with_sof && (i == 0);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic send(input logic [7:0] f[$], input exp_t e);
        if (f.size() >= 3)
            for (int i = 3; i < f.size() && i < 3 + int'(f[2]); i++) pay_q.push_back(f[i]);
        res_q.push_back(e);
        drive_bytes(f, 1'b1);
        in_eof = 1'b1;
        @(negedge clk);
        in_eof = 1'b0;
        repeat (3) @(negedge clk);
        check_drained(e.req);
    endtask

    // Monitor: pops expected items as the design produces results.
    always @(negedge clk) begin
        if (!rst) begin
            if (pay_valid) begin
                checks++;
                if (pay_q.size() == 0) begin
                    errors++;
                    $display("FAIL R2: unexpected payload byte %h, expected none", pay_data);
                end else begin
                    logic [7:0] xb;
                    xb = pay_q.pop_front();
                    if (pay_data !== xb) begin
                        errors++;
                        $display("FAIL R2: payload %h, expected %h", pay_data, xb);
                    end
                end
            end
            if (frame_valid || frame_error) begin
                checks++;
                if (res_q.size() == 0) begin
                    errors++;
                    $display("FAIL R3: unexpected result valid=%b error=%b, expected none",
                             frame_valid, frame_error);
                end else begin
                    exp_t er;
                    logic [14:0] got, want;
                    er   = res_q.pop_front();
                    got  = {frame_valid, frame_error, err_cause, blk_kind, seq_no, more_data,
                            ack_code, sup_resp, sup_code};
                    want = {er.cause == 2'b00, er.cause != 2'b00, er.cause, er.kind, er.seq,
                            er.more, er.ack, er.resp, er.code};
                    if (got !== want) begin
                        errors++;
                        $display("FAIL %s R12: result %h, expected %h", er.req, got, want);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [7:0] f[$];
        logic [7:0] junk[$];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({pay_valid, pay_data, frame_valid, frame_error, err_cause, blk_kind, seq_no,
             more_data, ack_code, sup_resp, sup_code} !== 27'd0) begin
            errors++;
            $display("FAIL R1: outputs not zero after reset, expected 0");
        end

        // Information blocks
        build(8'h5A, 8'h20, 8'd3, 3, 8'h11, f); send(f, mk(8'h20, 2'b00, "R5 info chained"));
        build(8'h5A, 8'h40, 8'd0, 0, 0, f);     send(f, mk(8'h40, 2'b00, "R5 info empty seq1"));
        build(8'h5A, 8'h01, 8'd1, 1, 3, f);     send(f, mk(8'h01, 2'b10, "R5 info reserved bit"));
        // Acknowledge blocks
        build(8'h5A, 8'h91, 8'd0, 0, 0, f);     send(f, mk(8'h91, 2'b00, "R6 ack crc code"));
        build(8'h5A, 8'h83, 8'd0, 0, 0, f);     send(f, mk(8'h83, 2'b10, "R6 ack code 11"));
        build(8'h5A, 8'hA0, 8'd0, 0, 0, f);     send(f, mk(8'hA0, 2'b10, "R6 ack reserved bit"));
        build(8'h5A, 8'h90, 8'd1, 1, 9, f);     send(f, mk(8'h90, 2'b10, "R6 ack with payload"));
        // Supervisory blocks
        build(8'h5A, 8'hC3, 8'd1, 1, 4, f);     send(f, mk(8'hC3, 2'b00, "R7 sup wtx request"));
        build(8'h5A, 8'hE1, 8'd1, 1, 5, f);     send(f, mk(8'hE1, 2'b00, "R7 sup ifs response"));
        build(8'h5A, 8'hCF, 8'd0, 0, 0, f);     send(f, mk(8'hCF, 2'b00, "R7 sup soft reset"));
        build(8'h5A, 8'hC4, 8'd0, 0, 0, f);     send(f, mk(8'hC4, 2'b10, "R7 sup unknown 4"));
        build(8'h5A, 8'hCA, 8'd0, 0, 0, f);     send(f, mk(8'hCA, 2'b10, "R7 sup unknown 0A"));
        // Check code
        build(8'h5A, 8'h00, 8'd2, 2, 6, f); f[f.size()-1] ^= 8'h01;
        send(f, mk(8'h00, 2'b01, "R4 crc mismatch"));
        // Address
        build(8'h55, 8'h00, 8'd0, 0, 0, f);     send(f, mk(8'h00, 2'b10, "R8 equal nibbles"));
        build(8'h00, 8'h00, 8'd0, 0, 0, f);     send(f, mk(8'h00, 2'b10, "R8 address 00"));
        build(8'hFF, 8'h40, 8'd0, 0, 0, f);     send(f, mk(8'h40, 2'b10, "R8 address FF"));
        // Length limits
        ifs_max = 8'd4;
        build(8'h5A, 8'h00, 8'd5, 5, 1, f);     send(f, mk(8'h00, 2'b10, "R9 above ifs_max"));
        build(8'h5A, 8'h40, 8'd4, 4, 2, f);     send(f, mk(8'h40, 2'b00, "R9 at ifs_max"));
        ifs_max = 8'd254;
        build(8'h5A, 8'h00, 8'hFF, 255, 8, f);  send(f, mk(8'h00, 2'b10, "R9 length FF"));
        build(8'h5A, 8'h20, 8'hFE, 254, 3, f);  send(f, mk(8'h20, 2'b00, "R9 length FE"));
        // Byte count
        build(8'h5A, 8'h00, 8'd3, 3, 7, f); void'(f.pop_back());
        send(f, mk(8'h00, 2'b10, "R10 short by one"));
        build(8'h5A, 8'h00, 8'd3, 3, 7, f); f = f[0:3];
        send(f, mk(8'h00, 2'b10, "R10 cut in payload"));
        build(8'h5A, 8'h40, 8'd1, 1, 7, f); f.push_back(8'h33);
        send(f, mk(8'h40, 2'b10, "R10 extra byte"));
        // Priority
        build(8'h55, 8'h01, 8'd0, 0, 0, f); f[f.size()-2] ^= 8'h80;
        send(f, mk(8'h01, 2'b01, "R11 crc over header fault"));
        // No open frame: stray bytes and end strobe
        junk = '{8'h5A, 8'h00, 8'h01, 8'h99};
        drive_bytes(junk, 1'b0);
        in_eof = 1'b1; @(negedge clk); in_eof = 1'b0;
        repeat (3) @(negedge clk);
        check_drained("R3 stray input ignored");
        // Restart: partial header then a fresh frame
        junk = '{8'h5A, 8'h00, 8'h05};
        drive_bytes(junk, 1'b1);
        build(8'h5A, 8'hC0, 8'd0, 0, 0, f);     send(f, mk(8'hC0, 2'b00, "R3 restart on sof"));

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule